// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps load-locked reservations for a set of requesting contexts, each one a CPU number paired with a thread number, and sits in front of a plain memory. A load-locked request records the granule address the context read. A write request is checked against the recorded set within the same cycle. The block then says whether the memory may take the write and, for a store-conditional, whether it succeeded. Every reservation whose granule the write touches is removed, whichever context owns it.

The table has one slot per context, so it can never overflow. Each slot has a valid flag and a granule address. Loads and writes arrive on two separate ports, so one load and one write can be presented in the same cycle. When that happens, the write is judged against the table as it stood before the cycle, and the load-locked update is applied after the write's clearing. The write decision and the store-conditional result are combinational from the write port and the current table. The table itself changes at the next rising clock edge.

Top module: `llsc_monitor`

## Requirements
- R1: After a synchronous active-low reset no context holds a reservation, so a store-conditional from any context fails.
- R2: A load-locked (`ld_valid`=1, `ld_locked`=1) records the granule of `ld_addr` for context (`ld_cpu`,`ld_thr`). A later store-conditional from that context to the same granule reports `sc_done`=1 and `sc_pass`=1, and drives `wr_grant`=1 in the cycle it is presented.
- R3: A context holds at most one reservation. A second load-locked from the same context replaces the recorded granule, so a store-conditional to the earlier granule then fails.
- R4: Addresses are compared as granules, meaning `addr >> GRAN_LSB`. With the default GRAN_LSB=3, two addresses that differ only in bits [2:0] match.
- R5: A plain store (`st_valid`=1, `st_cond`=0) always drives `wr_grant`=1 and leaves `sc_done`=0 and `sc_pass`=0.
- R6: A plain store removes every reservation in its granule, whichever context owns it. Reservations on other granules are kept.
- R7: A store-conditional defaults to failure. It passes only if the requesting context's own reservation holds the same granule; a reservation held by another context does not count. A failed store-conditional reports `sc_done`=1 and `sc_pass`=0 and drives `wr_grant`=0, so the memory is left unchanged.
- R8: A store-conditional, whether it passes or fails, removes every reservation in its granule from all contexts.
- R9: A load with `ld_locked`=0 neither creates nor removes a reservation.
- R10: When a load-locked and a write arrive in the same cycle, the write is judged against the earlier table. The new reservation is recorded afterwards and survives, even if it is in the written granule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Load request present |
| ld_locked | input | 1 | Load is a load-locked |
| ld_cpu | input | CPU_W | CPU number of the loading context |
| ld_thr | input | THR_W | Thread number of the loading context |
| ld_addr | input | ADDR_W | Load byte address |
| st_valid | input | 1 | Write request present |
| st_cond | input | 1 | Write is a store-conditional |
| st_cpu | input | CPU_W | CPU number of the writing context |
| st_thr | input | THR_W | Thread number of the writing context |
| st_addr | input | ADDR_W | Write byte address |
| wr_grant | output | 1 | The memory may perform this write |
| sc_done | output | 1 | A store-conditional result is reported this cycle |
| sc_pass | output | 1 | Store-conditional result: 1 = success, 0 = failure |

## Verification
A reference model of the reservation table, one valid flag and one granule per context, is stepped through a long pseudo-random mix of requests. The mix covers plain loads, load-locked requests, plain stores and store-conditionals from all eight contexts. Addresses are drawn from three granules with random low bits, so the same-granule, masked-offset and other-context cases all occur often. Directed sequences come first and separate behaviours that random traffic could confuse. They show that an overwritten reservation is lost, that a reservation held by another context does not satisfy a store-conditional, and that a failed store-conditional still clears other contexts' reservations. They also cover a load-locked and a write to the same granule in one cycle.

// File: rtl/llsc_pkg.sv
// Package: shared types and defaults for the load-linked reservation monitor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package llsc_pkg;

    // Default configuration: 4 CPUs by 2 threads, 8-byte granule.
    localparam int DEF_NUM_CPU  = 4;
    localparam int DEF_NUM_THR  = 2;
    localparam int DEF_ADDR_W   = 16;
    localparam int DEF_GRAN_LSB = 3;

    // Kind of write presented on the write port this cycle.
    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_PLAIN = 2'd1,
        WR_COND  = 2'd2
    } wr_kind_e;

    // Width helper that never returns zero.
    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/llsc_ctx_dec.sv
// Module: llsc_ctx_dec
// Turns a (cpu, thread) pair into a one-hot context select over
// NUM_CPU*NUM_THR slots. Context index = cpu*NUM_THR + thread.
// Assumes out-of-range cpu or thread values select no slot.
module llsc_ctx_dec #(
    parameter int NUM_CPU = 4,
    parameter int NUM_THR = 2,
    parameter int CPU_W   = 2,
    parameter int THR_W   = 1,
    localparam int NUM_CTX = NUM_CPU * NUM_THR
) (
    input  logic               en,
    input  logic [CPU_W-1:0]   cpu,
    input  logic [THR_W-1:0]   thr,
    output logic [NUM_CTX-1:0] sel
);

    // One comparator per slot, built from its own cpu/thread coordinates.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
            localparam int IDX = c * NUM_THR + t;
            assign sel[IDX] = en
                && (cpu == CPU_W'(c))
                && (thr == THR_W'(t));
        end
    end

endmodule

// File: rtl/llsc_entry.sv
// Module: llsc_entry
// One reservation slot: a valid flag and a granule address.
// Assumes set has priority over clr, so a load-locked is recorded
// after any write clearing in the same cycle.
module llsc_entry #(
    parameter int GRAN_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [GRAN_W-1:0] set_gran,
    input  logic              clr,
    output logic              valid,
    output logic [GRAN_W-1:0] gran
);

    // Update the valid flag: reset, record, or drop on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (set) begin
            valid <= 1'b1;
        end else if (clr) begin
            valid <= 1'b0;
        end
    end

    // Hold the granule address; it is loaded only on a load-locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gran <= '0;
        end else if (set) begin
            gran <= set_gran;
        end
    end

endmodule

// File: rtl/llsc_match.sv
// Module: llsc_match
// Compares the write granule against every slot. It gives the per-slot hit
// vector (the slots to clear) and whether the writer's own slot hits.
// Assumes own_sel is one-hot or zero.
module llsc_match #(
    parameter int NUM_CTX = 8,
    parameter int GRAN_W  = 13
) (
    input  logic [NUM_CTX-1:0]        valid,
    input  logic [NUM_CTX*GRAN_W-1:0] gran_flat,
    input  logic [GRAN_W-1:0]         wr_gran,
    input  logic [NUM_CTX-1:0]        own_sel,
    output logic [NUM_CTX-1:0]        hit,
    output logic                      own_hit
);

    // Per-slot address comparison.
    for (genvar i = 0; i < NUM_CTX; i++) begin : g_cmp
        assign hit[i] = valid[i] && (gran_flat[i*GRAN_W +: GRAN_W] == wr_gran);
    end

    // The writer's own reservation covers the written granule.
    assign own_hit = |(hit & own_sel);

endmodule

// File: rtl/llsc_monitor.sv
// Module: llsc_monitor (top)
// Load-linked reservation monitor in front of a simple memory.
// A load port records reservations and a write port is judged in the same
// cycle. Assumes one request per port per cycle. The write decision is
// combinational; the table changes at the next rising edge.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_CPU  = DEF_NUM_CPU,
    parameter int NUM_THR  = DEF_NUM_THR,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int GRAN_LSB = DEF_GRAN_LSB,
    localparam int CPU_W   = safe_clog2(NUM_CPU),
    localparam int THR_W   = safe_clog2(NUM_THR),
    localparam int NUM_CTX = NUM_CPU * NUM_THR,
    localparam int GRAN_W  = ADDR_W - GRAN_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              ld_locked,
    input  logic [CPU_W-1:0]  ld_cpu,
    input  logic [THR_W-1:0]  ld_thr,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic              st_cond,
    input  logic [CPU_W-1:0]  st_cpu,
    input  logic [THR_W-1:0]  st_thr,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              wr_grant,
    output logic              sc_done,
    output logic              sc_pass
);

    logic [NUM_CTX-1:0]        ld_sel;
    logic [NUM_CTX-1:0]        st_sel;
    logic [NUM_CTX-1:0]        resv_valid;
    logic [NUM_CTX*GRAN_W-1:0] resv_gran;
    logic [NUM_CTX-1:0]        hit;
    logic                      own_hit;
    logic [GRAN_W-1:0]         ld_gran;
    logic [GRAN_W-1:0]         st_gran;
    logic                      ll_req;
    wr_kind_e                  wr_kind;

    // Mask both addresses down to their reservation granule.
    assign ld_gran = ld_addr[ADDR_W-1:GRAN_LSB];
    assign st_gran = st_addr[ADDR_W-1:GRAN_LSB];
    assign ll_req  = ld_valid && ld_locked;

    // Classify the write presented this cycle.
    always_comb begin
        if (!st_valid)    wr_kind = WR_NONE;
        else if (st_cond) wr_kind = WR_COND;
        else              wr_kind = WR_PLAIN;
    end

    llsc_ctx_dec #(
        .NUM_CPU(NUM_CPU), .NUM_THR(NUM_THR), .CPU_W(CPU_W), .THR_W(THR_W)
    ) u_ld_dec (
        .en(ll_req), .cpu(ld_cpu), .thr(ld_thr), .sel(ld_sel)
    );

    llsc_ctx_dec #(
        .NUM_CPU(NUM_CPU), .NUM_THR(NUM_THR), .CPU_W(CPU_W), .THR_W(THR_W)
    ) u_st_dec (
        .en(st_valid), .cpu(st_cpu), .thr(st_thr), .sel(st_sel)
    );

    // One slot per context; a write hit clears, a load-locked sets.
    for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
        llsc_entry #(.GRAN_W(GRAN_W)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .set      (ld_sel[i]),
            .set_gran (ld_gran),
            .clr      (st_valid && hit[i]),
            .valid    (resv_valid[i]),
            .gran     (resv_gran[i*GRAN_W +: GRAN_W])
        );
    end

    llsc_match #(.NUM_CTX(NUM_CTX), .GRAN_W(GRAN_W)) u_match (
        .valid     (resv_valid),
        .gran_flat (resv_gran),
        .wr_gran   (st_gran),
        .own_sel   (st_sel),
        .hit       (hit),
        .own_hit   (own_hit)
    );

    // Write decision: plain stores always pass, conditional ones need own hit.
    always_comb begin
        wr_grant = 1'b0;
        sc_done  = 1'b0;
        sc_pass  = 1'b0;
        unique case (wr_kind)
            WR_PLAIN: wr_grant = 1'b1;
            WR_COND: begin
                sc_done  = 1'b1;
                sc_pass  = own_hit;
                wr_grant = own_hit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/llsc_monitor_chk.sv
// Module: llsc_monitor_chk
// Checker bound to llsc_monitor; it relates port behaviour to the
// reservation table over time. Assumes synchronous active-low reset.
module llsc_monitor_chk #(
    parameter int NUM_CTX = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ld_valid,
    input logic               ld_locked,
    input logic               st_valid,
    input logic               st_cond,
    input logic               wr_grant,
    input logic               sc_done,
    input logic               sc_pass,
    input logic [NUM_CTX-1:0] resv_valid
);

    // R5: a plain store is always allowed to write.
    p_plain_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_cond) |-> (wr_grant && !sc_done));

    // R7: a failed store-conditional never reaches memory.
    p_sc_fail_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !sc_pass) |-> !wr_grant);

    // R2: a success is only ever reported for a store-conditional.
    p_pass_only_sc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> (sc_done && st_valid && st_cond));

    // R2: a store-conditional can only pass if some reservation exists.
    p_pass_needs_resv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> (resv_valid != '0));

    // R6: a write with no load-locked never adds reservations.
    p_write_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !(ld_valid && ld_locked))
        |=> ($countones(resv_valid) <= $past($countones(resv_valid))));

    // R9: a plain load alone leaves the table untouched.
    p_plain_load_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_valid && !(ld_valid && ld_locked)) |=> $stable(resv_valid));

    // R10: a load-locked is recorded even alongside a write.
    p_ll_records_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_locked) |=> (resv_valid != '0));

endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_CTX(NUM_CTX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_locked  (ld_locked),
    .st_valid   (st_valid),
    .st_cond    (st_cond),
    .wr_grant   (wr_grant),
    .sc_done    (sc_done),
    .sc_pass    (sc_pass),
    .resv_valid (resv_valid)
);

// File: tb/llsc_monitor_bench.sv
// Bench for llsc_monitor: directed sequences, then a long pseudo-random
// sweep checked against a reference reservation model.
module llsc_monitor_bench;

    localparam int NCTX = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 0, ld_locked = 0;
    logic [1:0]  ld_cpu = 0;
    logic [0:0]  ld_thr = 0;
    logic [15:0] ld_addr = 0;
    logic        st_valid = 0, st_cond = 0;
    logic [1:0]  st_cpu = 0;
    logic [0:0]  st_thr = 0;
    logic [15:0] st_addr = 0;
    logic        wr_grant, sc_done, sc_pass;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference model: one valid flag and one granule per context.
    bit          m_valid [NCTX];
    logic [12:0] m_gran  [NCTX];

    always #10 clk = ~clk;

    llsc_monitor u_llsc_monitor (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_locked(ld_locked), .ld_cpu(ld_cpu),
        .ld_thr(ld_thr), .ld_addr(ld_addr),
        .st_valid(st_valid), .st_cond(st_cond), .st_cpu(st_cpu),
        .st_thr(st_thr), .st_addr(st_addr),
        .wr_grant(wr_grant), .sc_done(sc_done), .sc_pass(sc_pass)
    );

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before posedge, update model at posedge.
    task automatic step(input string tag,
                        input bit lv, input bit lk, input int lctx, input logic [15:0] la,
                        input bit sv, input bit sc, input int sctx, input logic [15:0] sa);
        logic [12:0] sg;
        bit own;
        @(negedge clk);
        ld_valid = lv; ld_locked = lk; ld_cpu = 2'(lctx / 2); ld_thr = 1'(lctx % 2);
        ld_addr = la;
        st_valid = sv; st_cond = sc; st_cpu = 2'(sctx / 2); st_thr = 1'(sctx % 2);
        st_addr = sa;
        #5;
        sg  = sa[15:3];
        own = m_valid[sctx] && (m_gran[sctx] == sg);
        check(tag, "wr_grant", wr_grant, sv && (!sc || own));
        check(tag, "sc_done",  sc_done,  sv && sc);
        check(tag, "sc_pass",  sc_pass,  sv && sc && own);
        @(posedge clk);
        if (sv) begin
            for (int i = 0; i < NCTX; i++)
                if (m_valid[i] && m_gran[i] == sg) m_valid[i] = 0;
        end
        if (lv && lk) begin
            m_valid[lctx] = 1;
            m_gran[lctx]  = la[15:3];
        end
    endtask

    task automatic ll(input string tag, input int c, input logic [15:0] a);
        step(tag, 1, 1, c, a, 0, 0, 0, 16'h0);
    endtask
    task automatic sc_op(input string tag, input int c, input logic [15:0] a);
        step(tag, 0, 0, 0, 16'h0, 1, 1, c, a);
    endtask
    task automatic st_op(input string tag, input int c, input logic [15:0] a);
        step(tag, 0, 0, 0, 16'h0, 1, 0, c, a);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NCTX; i++) begin m_valid[i] = 0; m_gran[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: after reset every context's store-conditional fails.
        for (int c = 0; c < NCTX; c++) sc_op("R1", c, 16'h0040);

        // R2: load-locked then store-conditional by the same context passes.
        ll("R2", 3, 16'h0100);
        sc_op("R2", 3, 16'h0100);
        sc_op("R8", 3, 16'h0100);          // reservation consumed, fails now

        // R3: a second load-locked replaces the first granule.
        ll("R3", 1, 16'h0200);
        ll("R3", 1, 16'h0300);
        sc_op("R3", 1, 16'h0200);
        sc_op("R3", 1, 16'h0300);

        // R4: different byte in the same 8-byte granule matches.
        ll("R4", 5, 16'h0408);
        sc_op("R4", 5, 16'h040F);
        ll("R4", 5, 16'h0408);
        sc_op("R4", 5, 16'h0410);          // next granule: fails

        // R5 and R6: a plain store clears every holder of its granule only.
        ll("R6", 0, 16'h0500); ll("R6", 2, 16'h0504); ll("R6", 4, 16'h0600);
        st_op("R5", 7, 16'h0507);
        sc_op("R6", 0, 16'h0500);
        sc_op("R6", 2, 16'h0500);
        sc_op("R6", 4, 16'h0600);

        // R7 and R8: another context's reservation does not help, and the
        // failing store-conditional still clears it.
        ll("R7", 6, 16'h0700);
        sc_op("R7", 7, 16'h0700);
        sc_op("R8", 6, 16'h0700);

        // R9: plain loads neither create nor clear reservations.
        step("R9", 1, 0, 2, 16'h0800, 0, 0, 0, 16'h0);
        sc_op("R9", 2, 16'h0800);
        ll("R9", 2, 16'h0800);
        step("R9", 1, 0, 2, 16'h0900, 0, 0, 0, 16'h0);
        sc_op("R9", 2, 16'h0800);

        // R10: same-cycle write and load-locked to one granule.
        step("R10", 1, 1, 4, 16'h0A00, 1, 0, 1, 16'h0A00);
        sc_op("R10", 4, 16'h0A00);
        ll("R10", 3, 16'h0B00);
        step("R10", 1, 1, 5, 16'h0B00, 1, 1, 3, 16'h0B00);
        sc_op("R10", 3, 16'h0B00);
        sc_op("R10", 5, 16'h0B00);

        // Sweep: pseudo-random mix over three granules and all contexts.
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] la, sa;
            bit lv, lk, sv, sc;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            la = (lfsr[1:0] == 0) ? 16'h0C00 : (lfsr[1:0] == 1) ? 16'h0C08 : 16'h0D00;
            la[2:0] = lfsr[4:2];
            sa = (lfsr[6:5] == 0) ? 16'h0C00 : (lfsr[6:5] == 1) ? 16'h0C08 : 16'h0D00;
            sa[2:0] = lfsr[9:7];
            lv = lfsr[10] | lfsr[11];
            lk = lfsr[12] | lfsr[3];
            sv = lfsr[13];
            sc = lfsr[14] | lfsr[0];
            step(sc ? "R7" : "R6", lv, lk, int'(lfsr[15:13]), la,
                 sv, sc, int'({lfsr[2], lfsr[8], lfsr[11]}), sa);
        end

        finished = 1;
        summary();
    end

endmodule